// File: doc/BRIEF.md
# Vector Compare and Mask Unit

This unit holds a small array of vector registers, each a row of signed integer elements, and runs one vector operation at a time over the first VL elements, one element per clock. A compare operation tests each element of one register against either the matching element of a second register or a scalar. It writes one bit per element into a mask register. Elementwise add and subtract then write their results only where the mask bit is set. A create-index operation fills a register with multiples of a scalar.

An operation begins with a one-cycle start pulse that captures the opcode, condition, register selects, scalar and length. The unit then walks element 0 upward and pulses done once the last element is handled. A direct write port and a combinational read port give access to the register array, so operands can be loaded and results can be read. The mask is always visible on its own output.

Top module: `vcm_unit`

## Requirements
- R1: After reset the mask output is all ones, busy and done are low, and every register element reads zero. An add run before any compare therefore updates every element below VL.
- R2: A vector-vector compare (op 0) sets mask bit i to the result of comparing A[i] with B[i] as signed numbers, for every i below VL. The condition codes are 0 equal, 1 not equal, 2 greater, 3 less, 4 greater-or-equal and 5 less-or-equal.
- R3: A vector-scalar compare (op 1) sets mask bit i to the result of the same signed condition applied to A[i] and the scalar input.
- R4: When a compare finishes, every mask bit at index VL or above is 0. A compare with VL of zero leaves the mask all zero.
- R5: Masked add (op 2) and masked subtract (op 3) write A[i]+B[i] or A[i]-B[i], wrapping modulo 2^W, into destination element i only when i is below VL and mask bit i is 1. All other destination elements keep their values.
- R6: done is a one-cycle pulse that appears VL clock edges after the edge that accepted start, whatever the mask holds. busy stays high between those two edges and is low while done is high.
- R7: Create-index (op 4) writes i times the scalar, wrapping modulo 2^W, into destination element i for every i below VL. It ignores the mask and leaves the mask unchanged.
- R8: A start pulse that arrives while busy is high is ignored. The running operation, its timing and all registers other than its destination are unaffected.
- R9: If the direct write port and the running operation write the same element in the same cycle, the operation's value is kept. A port write to a different element in that cycle still takes effect.
- R10: A requested length greater than the register length MVL is treated as MVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when busy is low |
| op_i | input | 3 | Operation code |
| cond_i | input | 3 | Compare condition code |
| src_a_i | input | RW | First source register |
| src_b_i | input | RW | Second source register |
| dst_i | input | RW | Destination register |
| scalar_i | input | W | Scalar operand |
| vl_i | input | LW | Requested vector length |
| wr_en_i | input | 1 | Direct element write enable |
| wr_reg_i | input | RW | Direct write register select |
| wr_idx_i | input | IW | Direct write element index |
| wr_data_i | input | W | Direct write data |
| rd_reg_i | input | RW | Read register select |
| rd_idx_i | input | IW | Read element index |
| rd_data_o | output | W | Read data, combinational |
| mask_o | output | MVL | Current mask register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished pulse |

## Verification
Two functions can land in the same cycle: a direct element write through the port and an element write from a running operation. The bench sets this up while create-index runs with length 4. It aims a port write at element 1 in the cycle the engine writes element 1, and in the next cycle aims a second port write at element 6, which lies beyond the length. The judgement is made at the read port once done has pulsed. Element 1 must hold the engine's value and element 6 must hold the port's value.

// File: rtl/vcm_pkg.sv
// Shared encodings for the vector compare and mask unit.
// Assumes op and condition codes are 3 bits wide.
package vcm_pkg;
    typedef enum logic [2:0] {
        OP_CMP_VV = 3'd0,
        OP_CMP_VS = 3'd1,
        OP_ADD    = 3'd2,
        OP_SUB    = 3'd3,
        OP_IDX    = 3'd4
    } vop_e;

    typedef enum logic [2:0] {
        C_EQ = 3'd0,
        C_NE = 3'd1,
        C_GT = 3'd2,
        C_LT = 3'd3,
        C_GE = 3'd4,
        C_LE = 3'd5
    } vcond_e;
endpackage

// File: rtl/vcm_regfile.sv
// Vector register array: NREG registers of MVL elements, each W bits wide.
// Two write ports, where the engine port wins over the direct port on the same
// element. Three combinational read ports. Assumes NREG and MVL are powers of two.
module vcm_regfile #(
    parameter int NREG = 4,
    parameter int MVL  = 8,
    parameter int W    = 16,
    parameter int RW   = $clog2(NREG),
    parameter int IW   = $clog2(MVL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eng_we,
    input  logic [RW-1:0] eng_reg,
    input  logic [IW-1:0] eng_idx,
    input  logic [W-1:0]  eng_data,
    input  logic          port_we,
    input  logic [RW-1:0] port_reg,
    input  logic [IW-1:0] port_idx,
    input  logic [W-1:0]  port_data,
    input  logic [RW-1:0] ra_reg,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [RW-1:0] rb_reg,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic [RW-1:0] rx_reg,
    input  logic [IW-1:0] rx_idx,
    output logic [W-1:0]  rx_data
);
    logic [W-1:0] mem [NREG][MVL];

    // Element storage update: engine write first, then the direct port.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            for (int e = 0; e < MVL; e++) begin
                if (!rst_n)
                    mem[r][e] <= '0;
                else if (eng_we && eng_reg == RW'(r) && eng_idx == IW'(e))
                    mem[r][e] <= eng_data;
                else if (port_we && port_reg == RW'(r) && port_idx == IW'(e))
                    mem[r][e] <= port_data;
            end
        end
    end

    assign ra_data = mem[ra_reg][ra_idx];
    assign rb_data = mem[rb_reg][rb_idx];
    assign rx_data = mem[rx_reg][rx_idx];
endmodule

// File: rtl/vcm_cmp.sv
// Signed element comparator for the six condition codes.
// An undefined code gives a false result.
module vcm_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic [2:0]   cond,
    output logic         hit
);
    import vcm_pkg::*;
    logic signed [W-1:0] sl, sr;
    assign sl = lhs;
    assign sr = rhs;

    // Condition decode.
    always_comb begin
        case (vcond_e'(cond))
            C_EQ:    hit = (sl == sr);
            C_NE:    hit = (sl != sr);
            C_GT:    hit = (sl >  sr);
            C_LT:    hit = (sl <  sr);
            C_GE:    hit = (sl >= sr);
            C_LE:    hit = (sl <= sr);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/vcm_seq.sv
// Element sequencer: accepts start when idle, clamps the length to MVL,
// steps the element index once per cycle and pulses done after the last one.
// A zero length finishes at once with no element cycle.
module vcm_seq #(
    parameter int MVL = 8,
    parameter int IW  = $clog2(MVL),
    parameter int LW  = $clog2(MVL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] vl_req,
    output logic          accept,
    output logic          busy,
    output logic [IW-1:0] idx,
    output logic [LW-1:0] len,
    output logic          done
);
    logic [LW-1:0] vl_eff;
    logic          last;

    assign accept = start && !busy;
    assign vl_eff = (vl_req > LW'(MVL)) ? LW'(MVL) : vl_req;
    assign last   = (LW'(idx) + LW'(1)) == len;

    // Run state, element index and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            len  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                len <= vl_eff;
                idx <= '0;
                if (vl_eff == '0) done <= 1'b1;
                else              busy <= 1'b1;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + IW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/vcm_unit.sv
// Vector compare and mask unit top. Captures an operation on start, then
// handles one element per cycle: a compare writes a mask bit, masked add or
// subtract writes only where the mask is set, and create-index writes i*scalar.
// Assumes operands are signed integers and the mask resets to all ones.
module vcm_unit #(
    parameter int NREG = 4,
    parameter int MVL  = 8,
    parameter int W    = 16,
    parameter int RW   = $clog2(NREG),
    parameter int IW   = $clog2(MVL),
    parameter int LW   = $clog2(MVL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2:0]     op_i,
    input  logic [2:0]     cond_i,
    input  logic [RW-1:0]  src_a_i,
    input  logic [RW-1:0]  src_b_i,
    input  logic [RW-1:0]  dst_i,
    input  logic [W-1:0]   scalar_i,
    input  logic [LW-1:0]  vl_i,
    input  logic           wr_en_i,
    input  logic [RW-1:0]  wr_reg_i,
    input  logic [IW-1:0]  wr_idx_i,
    input  logic [W-1:0]   wr_data_i,
    input  logic [RW-1:0]  rd_reg_i,
    input  logic [IW-1:0]  rd_idx_i,
    output logic [W-1:0]   rd_data_o,
    output logic [MVL-1:0] mask_o,
    output logic           busy_o,
    output logic           done_o
);
    import vcm_pkg::*;

    logic          accept, busy, done;
    logic [IW-1:0] idx_w;
    logic [LW-1:0] len_w;
    vop_e          op_q;
    logic [2:0]    cond_q;
    logic [RW-1:0] a_q, b_q, d_q;
    logic [W-1:0]  s_q;
    logic [W-1:0]  a_data, b_data, rhs, res;
    logic [MVL-1:0] mask_q;
    logic          hit, eng_we, is_cmp, start_cmp;

    vcm_seq #(.MVL(MVL), .IW(IW), .LW(LW)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start_i), .vl_req(vl_i),
        .accept(accept), .busy(busy), .idx(idx_w), .len(len_w), .done(done)
    );

    // Operand capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_CMP_VV;
            cond_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
            d_q    <= '0;
            s_q    <= '0;
        end else if (accept) begin
            op_q   <= vop_e'(op_i);
            cond_q <= cond_i;
            a_q    <= src_a_i;
            b_q    <= src_b_i;
            d_q    <= dst_i;
            s_q    <= scalar_i;
        end
    end

    assign is_cmp    = (op_q == OP_CMP_VV) || (op_q == OP_CMP_VS);
    assign start_cmp = accept && (op_i == 3'(OP_CMP_VV) || op_i == 3'(OP_CMP_VS));
    assign rhs       = (op_q == OP_CMP_VS) ? s_q : b_data;

    vcm_cmp #(.W(W)) cmp_i (.lhs(a_data), .rhs(rhs), .cond(cond_q), .hit(hit));

    // Element result for the writing operations.
    always_comb begin
        case (op_q)
            OP_ADD:  res = a_data + b_data;
            OP_SUB:  res = a_data - b_data;
            OP_IDX:  res = s_q * W'(idx_w);
            default: res = '0;
        endcase
    end

    assign eng_we = busy && (((op_q == OP_ADD || op_q == OP_SUB) && mask_q[idx_w])
                             || op_q == OP_IDX);

    vcm_regfile #(.NREG(NREG), .MVL(MVL), .W(W), .RW(RW), .IW(IW)) rf_i (
        .clk(clk), .rst_n(rst_n),
        .eng_we(eng_we), .eng_reg(d_q), .eng_idx(idx_w), .eng_data(res),
        .port_we(wr_en_i), .port_reg(wr_reg_i), .port_idx(wr_idx_i), .port_data(wr_data_i),
        .ra_reg(a_q), .ra_idx(idx_w), .ra_data(a_data),
        .rb_reg(b_q), .rb_idx(idx_w), .rb_data(b_data),
        .rx_reg(rd_reg_i), .rx_idx(rd_idx_i), .rx_data(rd_data_o)
    );

    // Mask register: cleared when a compare starts, then one bit per element.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (start_cmp)
            mask_q <= '0;
        else if (busy && is_cmp)
            mask_q[idx_w] <= hit;
    end

    assign mask_o = mask_q;
    assign busy_o = busy;
    assign done_o = done;
endmodule

// File: rtl/vcm_unit_chk.sv
// Property checker for vcm_unit, attached by bind. Counts cycles since the
// accepted start so that the length window needs no deep $past.
module vcm_unit_chk #(
    parameter int MVL = 8,
    parameter int IW  = $clog2(MVL),
    parameter int LW  = $clog2(MVL + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [MVL-1:0] mask_o,
    input logic [LW-1:0]  len_q,
    input logic [IW-1:0]  idx_q,
    input logic [2:0]     op_q,
    input logic           eng_we
);
    logic [LW-1:0]  cyc;
    logic [MVL-1:0] lenmask;

    // Cycles elapsed since the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cyc <= '0;
        else if (start_i && !busy_o)   cyc <= '0;
        else if (busy_o)               cyc <= cyc + LW'(1);
    end

    // Bits that lie below the captured length.
    always_comb begin
        for (int i = 0; i < MVL; i++) lenmask[i] = (LW'(i) < len_q);
    end

    // R6
    done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cyc == len_q));
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R5
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (op_q == 3'd2 || op_q == 3'd3) && !mask_o[idx_q]) |-> !eng_we);
    // R4
    len_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q <= 3'd1) |-> ((mask_o & ~lenmask) == '0));
    // R8
    hold_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(op_q));
    // R10
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (len_q <= LW'(MVL) && LW'(idx_q) < len_q));
endmodule

bind vcm_unit vcm_unit_chk #(.MVL(MVL), .IW(IW), .LW(LW)) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .mask_o(mask_o), .len_q(len_w), .idx_q(idx_w), .op_q(op_q), .eng_we(eng_we)
);

// File: tb/vcm_unit_tb_top.sv
// Scoreboard bench: the driver task updates a reference model and queues the
// expected mask; a monitor pops and compares it on every done pulse.
module vcm_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 4, MVL = 8, W = 16;
    localparam int RW = $clog2(NREG), IW = $clog2(MVL), LW = $clog2(MVL + 1);

    logic clk = 0, rst_n = 0;
    logic start_i = 0;
    logic [2:0] op_i = 0, cond_i = 0;
    logic [RW-1:0] src_a_i = 0, src_b_i = 0, dst_i = 0;
    logic [W-1:0] scalar_i = 0;
    logic [LW-1:0] vl_i = 0;
    logic wr_en_i = 0;
    logic [RW-1:0] wr_reg_i = 0;
    logic [IW-1:0] wr_idx_i = 0;
    logic [W-1:0] wr_data_i = 0;
    logic [RW-1:0] rd_reg_i = 0;
    logic [IW-1:0] rd_idx_i = 0;
    logic [W-1:0] rd_data_o;
    logic [MVL-1:0] mask_o;
    logic busy_o, done_o;

    int checks = 0, fails = 0;
    logic [W-1:0] mdl [NREG][MVL];
    logic [MVL-1:0] mmask;
    logic [MVL-1:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vcm_unit #(.NREG(NREG), .MVL(MVL), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .cond_i(cond_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i), .scalar_i(scalar_i),
        .vl_i(vl_i), .wr_en_i(wr_en_i), .wr_reg_i(wr_reg_i), .wr_idx_i(wr_idx_i),
        .wr_data_i(wr_data_i), .rd_reg_i(rd_reg_i), .rd_idx_i(rd_idx_i),
        .rd_data_o(rd_data_o), .mask_o(mask_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic bit ref_cond(input int c, input logic signed [W-1:0] x,
                                    input logic signed [W-1:0] y);
        case (c)
            0: return x == y;
            1: return x != y;
            2: return x > y;
            3: return x < y;
            4: return x >= y;
            5: return x <= y;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Monitor: compare the mask on every done pulse against the queued item.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R6: unexpected done, actual 1 expected 0");
            end else begin
                automatic logic [MVL-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check({t, " mask"}, mask_o, e);
            end
        end
    end

    task automatic poke_wr(input int r, input int i, input logic [W-1:0] d);
        @(negedge clk);
        wr_en_i = 1; wr_reg_i = RW'(r); wr_idx_i = IW'(i); wr_data_i = d;
        mdl[r][i] = d;
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic check_regs(input string req);
        for (int r = 0; r < NREG; r++) begin
            automatic int bad = -1;
            automatic logic [W-1:0] got = 0;
            for (int i = 0; i < MVL; i++) begin
                rd_reg_i = RW'(r); rd_idx_i = IW'(i); #1;
                if (rd_data_o !== mdl[r][i] && bad < 0) begin bad = i; got = rd_data_o; end
            end
            if (bad < 0) check({req, " regs"}, 0, 0);
            else check($sformatf("%s reg%0d[%0d]", req, r, bad), got, mdl[r][bad]);
        end
    endtask

    // mode 0 plain, 1 start pulse while busy, 2 port writes during the run
    task automatic run_op(input int op, input int cnd, input int a, input int b,
                          input int d, input int s, input int vl, input string tag,
                          input int mode);
        automatic int vle = (vl > MVL) ? MVL : vl;
        automatic int k;
        automatic logic [W-1:0] sv = W'(s);
        if (op <= 1) begin
            mmask = '0;
            for (int i = 0; i < vle; i++)
                mmask[i] = ref_cond(cnd, mdl[a][i], (op == 1) ? sv : mdl[b][i]);
        end else begin
            for (int i = 0; i < vle; i++) begin
                if (op == 2 && mmask[i]) mdl[d][i] = mdl[a][i] + mdl[b][i];
                if (op == 3 && mmask[i]) mdl[d][i] = mdl[a][i] - mdl[b][i];
                if (op == 4)             mdl[d][i] = W'(i * s);
            end
        end
        if (mode == 2) mdl[d][6] = 16'h0BAD;
        exp_q.push_back(mmask);
        tag_q.push_back(tag);
        @(negedge clk);
        start_i = 1; op_i = 3'(op); cond_i = 3'(cnd); src_a_i = RW'(a); src_b_i = RW'(b);
        dst_i = RW'(d); scalar_i = sv; vl_i = LW'(vl);
        @(negedge clk);
        start_i = 0;
        k = 1;
        while (!done_o && k < 40) begin
            start_i = 0; wr_en_i = 0;
            if (mode == 1 && k == 2) begin
                start_i = 1; op_i = 3'd4; dst_i = 2'd3; scalar_i = 16'd77; vl_i = LW'(8);
            end
            if (mode == 2 && k == 2) begin
                wr_en_i = 1; wr_reg_i = RW'(d); wr_idx_i = 3'd1; wr_data_i = 16'h1234;
            end
            if (mode == 2 && k == 3) begin
                wr_en_i = 1; wr_reg_i = RW'(d); wr_idx_i = 3'd6; wr_data_i = 16'h0BAD;
            end
            @(negedge clk);
            k++;
        end
        start_i = 0; wr_en_i = 0;
        check({"R6 done timing ", tag}, k, vle + 1);
        check_regs(tag);
    endtask

    initial begin
        for (int r = 0; r < NREG; r++)
            for (int i = 0; i < MVL; i++) mdl[r][i] = '0;
        mmask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 mask", mask_o, {MVL{1'b1}});
        check("R1 busy", busy_o, 0);
        check("R1 done", done_o, 0);
        check_regs("R1");
        // operands
        poke_wr(0, 0, 5);   poke_wr(0, 1, -3);  poke_wr(0, 2, 7);  poke_wr(0, 3, 0);
        poke_wr(0, 4, -8);  poke_wr(0, 5, 2);   poke_wr(0, 6, 2);  poke_wr(0, 7, -1);
        poke_wr(1, 0, 5);   poke_wr(1, 1, 4);   poke_wr(1, 2, -7); poke_wr(1, 3, 0);
        poke_wr(1, 4, 3);   poke_wr(1, 5, 2);   poke_wr(1, 6, 9);  poke_wr(1, 7, -1);
        for (int i = 0; i < MVL; i++) poke_wr(2, i, 100 + i);
        run_op(2, 0, 0, 1, 2, 0, 8, "R1 add with reset mask", 0);
        for (int c = 0; c < 6; c++) run_op(0, c, 0, 1, 0, 0, 8, "R2 vv compare", 0);
        run_op(1, 2, 0, 0, 0, 1, 6, "R3 vs compare", 0);
        run_op(1, 5, 1, 0, 0, -1, 7, "R3 vs compare le", 0);
        run_op(2, 0, 0, 1, 2, 0, 8, "R5 masked add", 0);
        run_op(0, 0, 0, 1, 0, 0, 5, "R4 short compare", 0);
        run_op(3, 0, 2, 0, 2, 0, 8, "R5 masked sub", 0);
        run_op(4, 0, 0, 0, 3, 3, 8, "R7 index", 0);
        run_op(4, 0, 0, 0, 3, -2, 5, "R7 index negative", 0);
        run_op(0, 4, 0, 1, 0, 0, 0, "R4 zero length", 0);
        run_op(0, 5, 0, 1, 0, 0, 12, "R10 over length", 0);
        run_op(1, 1, 0, 0, 0, 0, 6, "R8 start while busy", 1);
        run_op(4, 0, 0, 0, 2, 5, 4, "R9 write collision", 2);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule